// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block connects the four PCI interrupt request lines (A, B, C and D) to a bank of ISA-style IRQ lines. Each PCI line has its own byte-wide steering register. The register either names the destination IRQ number or turns the route off. Software sets the steering through a simple byte register port, which has an address, write data, a write enable and a registered read-data output. The register window starts at a configurable base address, which defaults to 0x60.

The routing network is purely combinational. Each IRQ output is the OR of every PCI line that is currently enabled and steered to that IRQ number, so several PCI lines can share one IRQ. A build-time parameter produces a reduced variant that has no steering. In that variant the window holds no registers, writes to it are dropped, reads of it return zero and no IRQ output is ever driven.

All pins are plain control and status signals. There is no streamed data and no back-pressure. The register port accepts one access per cycle with no handshake.

Top module: `pirq_steer_router`

## Requirements
- R1: After reset, all four steering registers read 0x80, every route is off, and `irq_out` is all zero whatever `pci_int` does.
- R2: Each write is masked with 0x8F, so bits 6:4 of a steering register always read as zero, while bits 7 and 3:0 read back as written.
- R3: Address BASE+0 steers line A (`pci_int[0]`), BASE+1 line B, BASE+2 line C and BASE+3 line D. A write to any address outside this window changes no register.
- R4: When bit 7 of a steering register is 1, its PCI line drives no IRQ output.
- R5: When bit 7 is 0, bits 3:0 give the IRQ number. `irq_out[n]` then follows the PCI line combinationally, in the same cycle.
- R6: When several enabled routes select the same IRQ number, that output is the OR of their PCI lines.
- R7: `rd_data` is registered. It shows the byte at the `rd_addr` value sampled on the previous rising edge, and that byte is the register value before any write at the same edge. A read outside the window returns 0x00.
- R8: With `STEER_PRESENT` = 0, writes to the window are dropped, reads of the window return 0x00, and `irq_out` stays zero.
- R9: A write takes effect on the routing from the clock edge that captures it. Before that edge, the previous routing holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write enable for the register port |
| cfg_waddr | input | 8 | Write byte address |
| cfg_wdata | input | 8 | Write data |
| cfg_raddr | input | 8 | Read byte address |
| rd_data | output | 8 | Registered read data |
| pci_int | input | 4 | PCI interrupt lines A..D (bit 0 = A), active high |
| irq_out | output | 16 | Steered IRQ lines, active high |

## Verification
The bench writes all ones and reads back 0x8F. A design that kept the reserved bits would return 0xFF. It aims two or three lines at one IRQ and checks the OR: a design that gave one line priority would drop the other when the first goes low. It turns a route off while keeping a live IRQ field, which catches a network that ignores bit 7. It writes just outside the window and checks the neighbouring registers, which catches a loose address decode. It reads on the same edge as a write, which would expose a read path that forwards the new value. It probes the routing in the half cycle before a write edge to confirm the old route still holds. A second instance built without steering must stay silent and read zero, which would fail if the parameter were not honoured.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int unsigned ROUTE_IRQ_W = 4;
  localparam logic [7:0] ROUTE_WMASK = 8'h8F;
  localparam logic [7:0] ROUTE_RESET = 8'h80;

  typedef struct packed {
    logic                   off;
    logic [ROUTE_IRQ_W-1:0] irq;
  } route_t;

  function automatic route_t byte_to_route(input logic [7:0] b);
    route_t r;
    r.off = b[7];
    r.irq = b[ROUTE_IRQ_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_pkg::*;
#(
  parameter int unsigned NUM_PIRQ      = 4,
  parameter int unsigned ADDR_W        = 8,
  parameter logic [7:0]  BASE_ADDR     = 8'h60,
  parameter bit          STEER_PRESENT = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [7:0]                 wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [7:0]                 rd_data,
  output route_t [NUM_PIRQ-1:0]      routes
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

  logic [ADDR_W-1:0] wr_off, rd_off;
  assign wr_off = wr_addr - BASE;
  assign rd_off = rd_addr - BASE;

  generate
    if (STEER_PRESENT) begin : g_full
      logic [NUM_PIRQ-1:0][7:0] entry;
      logic [7:0]               rd_next;

      for (genvar i = 0; i < NUM_PIRQ; i++) begin : g_entry
        logic hit_w;
        assign hit_w = wr_en && (wr_off == ADDR_W'(i));

        always_ff @(posedge clk) begin
          if (!rst_n)      entry[i] <= ROUTE_RESET;
          else if (hit_w)  entry[i] <= wr_data & ROUTE_WMASK;
        end

        assign routes[i] = byte_to_route(entry[i]);

        // R9: a captured write lands masked in its own entry
        a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
          (wr_en && wr_addr == BASE + ADDR_W'(i)) |=> (entry[i] == ($past(wr_data) & 8'h8F)));
        // R3: writes aimed elsewhere leave this entry alone
        a_r3_foreign_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
          (!wr_en || wr_addr != BASE + ADDR_W'(i)) |=> $stable(entry[i]));
        // R1: first active cycle shows the reset value
        a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
          $rose(rst_n) |-> (entry[i] == 8'h80));
      end

      always_comb begin
        rd_next = 8'h00;
        for (int i = 0; i < NUM_PIRQ; i++)
          if (rd_off == ADDR_W'(i)) rd_next = entry[i];
      end

      always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= 8'h00;
        else        rd_data <= rd_next;
      end
    end else begin : g_lite
      for (genvar i = 0; i < NUM_PIRQ; i++) begin : g_tie
        assign routes[i] = byte_to_route(ROUTE_RESET);
      end
      always_ff @(posedge clk) begin
        rd_data <= 8'h00;
      end
    end
  endgenerate

  // R2: reserved bits never appear on the read port
  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6:4] == 3'b000);
endmodule

// File: rtl/pirq_route_net.sv
module pirq_route_net
  import pirq_pkg::*;
#(
  parameter int unsigned NUM_PIRQ = 4,
  parameter int unsigned NUM_IRQ  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  route_t [NUM_PIRQ-1:0] routes,
  input  logic [NUM_PIRQ-1:0]   pirq_in,
  output logic [NUM_IRQ-1:0]    irq_out
);
  logic [NUM_PIRQ-1:0] live;

  for (genvar i = 0; i < NUM_PIRQ; i++) begin : g_live
    assign live[i] = pirq_in[i] & ~routes[i].off;
  end

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
    always_comb begin
      irq_out[k] = 1'b0;
      for (int i = 0; i < NUM_PIRQ; i++)
        if (live[i] && (int'(routes[i].irq) == k)) irq_out[k] = 1'b1;
    end
  end

  // R4/R6: never more IRQ lines raised than live enabled PCI lines
  a_r4_no_stray_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_out) <= $countones(live));
  // R4: nothing live means nothing out
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (live == '0) |-> (irq_out == '0));
endmodule

// File: rtl/pirq_steer_router.sv
module pirq_steer_router
  import pirq_pkg::*;
#(
  parameter int unsigned NUM_PIRQ      = 4,
  parameter int unsigned NUM_IRQ       = 16,
  parameter int unsigned ADDR_W        = 8,
  parameter logic [7:0]  BASE_ADDR     = 8'h60,
  parameter bit          STEER_PRESENT = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_waddr,
  input  logic [7:0]          cfg_wdata,
  input  logic [ADDR_W-1:0]   cfg_raddr,
  output logic [7:0]          rd_data,
  input  logic [NUM_PIRQ-1:0] pci_int,
  output logic [NUM_IRQ-1:0]  irq_out
);
  route_t [NUM_PIRQ-1:0] routes;

  pirq_route_regs #(
    .NUM_PIRQ(NUM_PIRQ), .ADDR_W(ADDR_W),
    .BASE_ADDR(BASE_ADDR), .STEER_PRESENT(STEER_PRESENT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_addr(cfg_waddr), .wr_data(cfg_wdata),
    .rd_addr(cfg_raddr), .rd_data(rd_data),
    .routes(routes)
  );

  pirq_route_net #(
    .NUM_PIRQ(NUM_PIRQ), .NUM_IRQ(NUM_IRQ)
  ) u_net (
    .clk(clk), .rst_n(rst_n),
    .routes(routes), .pirq_in(pci_int), .irq_out(irq_out)
  );

  if (!STEER_PRESENT) begin : g_lite_chk
    // R8: reduced build stays silent and reads zero
    a_r8_lite_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out == '0) && (rd_data == 8'h00));
  end
endmodule

// File: tb/pirq_steer_router_tb.sv
module pirq_steer_router_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_waddr = '0, cfg_wdata = '0, cfg_raddr = '0;
  logic [3:0] pci_int = '0;
  logic [7:0] rd_data, rd_lite;
  logic [15:0] irq_out, irq_lite;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [4];

  always #5 clk = ~clk;

  pirq_steer_router u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .rd_data(rd_data),
    .pci_int(pci_int), .irq_out(irq_out)
  );

  pirq_steer_router #(.STEER_PRESENT(1'b0)) u_dut_lite (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .rd_data(rd_lite),
    .pci_int(pci_int), .irq_out(irq_lite)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_irq(input logic [3:0] p);
    logic [15:0] r = '0;
    for (int i = 0; i < 4; i++)
      if (p[i] && !model[i][7]) r[model[i][3:0]] = 1'b1;
    return r;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a >= 8'h60 && a <= 8'h63) model[a - 8'h60] = d & 8'h8F;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    cfg_raddr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int i = 0; i < 4; i++) begin
      rd(8'h60 + 8'(i), d);
      check("R1 reset value", {8'h0, d}, 16'h0080);
    end
    pci_int = 4'hF; #1;
    check("R1 all routes off", irq_out, 16'h0000);
    pci_int = 4'h0;
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(8'h60, 8'hFF); rd(8'h60, d);
    check("R2 mask 0xFF", {8'h0, d}, 16'h008F);
    wr(8'h60, 8'h75); rd(8'h60, d);
    check("R2 mask 0x75", {8'h0, d}, 16'h0005);
  endtask

  task automatic t_single();
    pci_int = 4'b0001; #1;
    check("R5 INTA to IRQ5", irq_out, 16'h0020);
    pci_int = 4'b0000; #1;
    check("R5 INTA low", irq_out, 16'h0000);
  endtask

  task automatic t_map_share();
    logic [7:0] d;
    wr(8'h61, 8'h0A); wr(8'h62, 8'h0A); wr(8'h63, 8'h03);
    rd(8'h63, d);
    check("R3 INTD register", {8'h0, d}, 16'h0003);
    pci_int = 4'b1000; #1;
    check("R3 INTD to IRQ3", irq_out, 16'h0008);
    pci_int = 4'b0010; #1;
    check("R6 share B only", irq_out, 16'h0400);
    pci_int = 4'b0100; #1;
    check("R6 share C only", irq_out, 16'h0400);
    pci_int = 4'b1111; #1;
    check("R6 all lines", irq_out, expect_irq(4'b1111));
    pci_int = 4'b0000;
  endtask

  task automatic t_disable();
    wr(8'h62, 8'h8A);
    pci_int = 4'b0100; #1;
    check("R4 disabled C silent", irq_out, 16'h0000);
    pci_int = 4'b0110; #1;
    check("R4 B still routed", irq_out, 16'h0400);
    pci_int = 4'b0000;
  endtask

  task automatic t_window();
    logic [7:0] d;
    wr(8'h64, 8'h00); wr(8'h5F, 8'h00);
    rd(8'h60, d); check("R3 out-of-window keeps A", {8'h0, d}, {8'h0, model[0]});
    rd(8'h63, d); check("R3 out-of-window keeps D", {8'h0, d}, {8'h0, model[3]});
    rd(8'h64, d); check("R7 read outside window", {8'h0, d}, 16'h0000);
  endtask

  task automatic t_timing();
    // R9: route switches only at the capturing edge
    pci_int = 4'b0001;
    @(negedge clk);
    cfg_we = 1'b1; cfg_waddr = 8'h60; cfg_wdata = 8'h07; cfg_raddr = 8'h60;
    #1;
    check("R9 old route before edge", irq_out, 16'h0020);
    @(negedge clk);
    cfg_we = 1'b0;
    check("R7 read sees pre-write value", {8'h0, rd_data}, 16'h0005);
    model[0] = 8'h07;
    check("R9 new route after edge", irq_out, 16'h0080);
    @(negedge clk);
    check("R7 next read sees new value", {8'h0, rd_data}, 16'h0007);
    pci_int = 4'b0000;
  endtask

  task automatic t_lite();
    pci_int = 4'hF; #1;
    check("R8 lite irq zero", irq_lite, 16'h0000);
    @(negedge clk); cfg_raddr = 8'h60;
    @(negedge clk);
    check("R8 lite read zero", {8'h0, rd_lite}, 16'h0000);
    pci_int = 4'h0;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 8'h80;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mask();
    t_single();
    t_map_share();
    t_disable();
    t_window();
    t_timing();
    t_lite();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule